// File: doc/BRIEF.md
# Packed Halfword Shift Unit

This unit shifts every 16-bit lane of a packed source word by one common amount in a single operation. It supports a plain left shift and a left shift that clamps to the signed 16-bit range. It also supports logical and arithmetic right shifts, each with an optional round-to-nearest form. The amount is four bits wide. It is taken either from an immediate input or from the four low bits of a second operand word.

An operation is presented with `inValid` high. The packed result, `outValid` and a one-cycle `ovSet` pulse appear one clock later. `ovSet` marks that at least one lane was clamped. A sticky status bit outside the unit may collect that pulse. The unit never clears such a bit.

The word width is a parameter, either 32 or 64. The lane count is the width divided by 16, and all lanes are computed in parallel.

Top module: `shift16_unit`

## Requirements
- R1: The source word is split into XLEN/16 independent 16-bit lanes, with lane k occupying bits [16k+15:16k]. The result of an operation presented with `inValid` high appears on `result`, with `outValid` high, exactly one clock later. `outValid` is low in a cycle that follows a clock with `inValid` low.
- R2: When `useImm` is 1 the shift amount is `immAmt`. When `useImm` is 0 the amount is `srcB[3:0]`, and `srcB` bits above bit 3 have no effect on any output.
- R3: `opSel` 0 selects the plain left shift. Vacated low bits are filled with zeros and bits shifted past bit 15 are dropped.
- R4: `opSel` 1 selects the clamping left shift. The lane is shifted as a signed value at full precision. A result above 32767 becomes 0x7FFF, a result below -32768 becomes 0x8000, and any other result keeps its low 16 bits.
- R5: `ovSet` is high for one cycle, together with `outValid`, exactly when some lane of a clamping left shift was clamped. It is low for every other operation.
- R6: `opSel` 2 selects the logical right shift, which fills vacated high bits with zeros.
- R7: `opSel` 4 selects the arithmetic right shift, which fills vacated high bits with copies of the lane's bit 15.
- R8: `opSel` 3 and `opSel` 5 select the rounding forms of the logical and arithmetic right shifts. Each lane yields floor((v + 2^(n-1)) / 2^n) without wraparound, where n is the amount and v is the lane read as unsigned (code 3) or signed (code 5). For example, 0xFFFF shifted by 1 with code 3 gives 0x8000.
- R9: A shift amount of zero returns every lane unchanged for every operation, and `ovSet` stays low.
- R10: `opSel` codes 6 and 7 return the source word unchanged, and `ovSet` stays low.
- R11: While `rst_n` is low, `outValid`, `result` and `ovSet` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 3 | Operation code (see R3 to R10) |
| useImm | input | 1 | 1: amount from `immAmt`, 0: from `srcB[3:0]` |
| immAmt | input | 4 | Immediate shift amount |
| srcA | input | XLEN | Packed source lanes |
| srcB | input | XLEN | Register amount operand (low 4 bits used) |
| outValid | output | 1 | Result valid |
| result | output | XLEN | Packed shifted lanes |
| ovSet | output | 1 | One-cycle pulse: a lane was clamped |

## Verification
The bench builds the unit with XLEN = 64. With four lanes, one word can hold lanes that clamp high, lanes that clamp low and lanes that do not clamp at all. This tests that `ovSet` is the OR across lanes and that no bit crosses a lane boundary. Directed cases cover zero amounts, reserved codes, the no-wrap rounding corner and junk in the upper `srcB` bits. A long run of random codes, amounts and lane values follows, and each result is checked against a behavioural model that uses integers.

// File: rtl/shift16_pkg.sv
package shift16_pkg;

  localparam int LANE_W = 16;
  localparam int AMT_W  = 4;

  typedef enum logic [2:0] {
    OP_SLL  = 3'd0,
    OP_SATL = 3'd1,
    OP_SRL  = 3'd2,
    OP_SRLR = 3'd3,
    OP_SRA  = 3'd4,
    OP_SRAR = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } shOp_e;

  // Strobes from the control decode to every lane of the datapath.
  typedef struct packed {
    logic             goLeft;
    logic             clampEn;
    logic             goRight;
    logic             fillSign;
    logic             roundEn;
    logic             bypass;
    logic [AMT_W-1:0] amt;
  } shCtrl_t;

endpackage

// File: rtl/shift16_ctrl.sv
module shift16_ctrl
  import shift16_pkg::*;
(
  input  logic [2:0]       opSel,
  input  logic             useImm,
  input  logic [AMT_W-1:0] immAmt,
  input  logic [AMT_W-1:0] regAmt,
  output shCtrl_t          ctl
);

  logic [AMT_W-1:0] amtSel;
  logic             rsvCode;

  assign amtSel = useImm ? immAmt : regAmt;

  always_comb begin
    ctl          = '0;
    ctl.amt      = amtSel;
    rsvCode      = 1'b0;
    case (shOp_e'(opSel))
      OP_SLL:  ctl.goLeft = 1'b1;
      OP_SATL: begin
        ctl.goLeft  = 1'b1;
        ctl.clampEn = 1'b1;
      end
      OP_SRL:  ctl.goRight = 1'b1;
      OP_SRLR: begin
        ctl.goRight = 1'b1;
        ctl.roundEn = 1'b1;
      end
      OP_SRA:  begin
        ctl.goRight  = 1'b1;
        ctl.fillSign = 1'b1;
      end
      OP_SRAR: begin
        ctl.goRight  = 1'b1;
        ctl.fillSign = 1'b1;
        ctl.roundEn  = 1'b1;
      end
      default: rsvCode = 1'b1;
    endcase
    // Zero amount and reserved codes both hand the lane through untouched.
    ctl.bypass = rsvCode | (amtSel == '0);
  end

  // R3 / R6: left and right strobes never both active.
  always_comb begin
    a_r3_dir_exclusive: assert ($onehot0({ctl.goLeft, ctl.goRight}));
  end

endmodule

// File: rtl/shift16_lane.sv
module shift16_lane
  import shift16_pkg::*;
(
  input  shCtrl_t           ctl,
  input  logic [LANE_W-1:0] laneIn,
  output logic [LANE_W-1:0] laneOut,
  output logic              laneSat
);

  localparam int WIDE_W = 2 * LANE_W;
  localparam int EXT_W  = LANE_W + 1;

  // Left path: signed, full precision.
  logic signed [WIDE_W-1:0] wideL;
  logic                     satHi;
  logic                     satLo;
  logic [LANE_W-1:0]        leftRes;

  assign wideL = $signed({{LANE_W{laneIn[LANE_W-1]}}, laneIn}) <<< ctl.amt;
  assign satHi = wideL > $signed(WIDE_W'(32767));
  assign satLo = wideL < $signed(-WIDE_W'(32768));

  always_comb begin
    if (!ctl.clampEn)  leftRes = laneIn << ctl.amt;
    else if (satHi)    leftRes = 16'h7FFF;
    else if (satLo)    leftRes = 16'h8000;
    else               leftRes = LANE_W'(wideL);
  end

  // Right path: one 17-bit extension serves logical and arithmetic forms.
  logic signed [EXT_W-1:0] extS;
  logic signed [EXT_W-1:0] plainS;
  logic signed [EXT_W-1:0] preS;
  logic signed [EXT_W-1:0] sumS;
  logic [AMT_W-1:0]        amtM1;
  logic [LANE_W-1:0]       rightRes;

  assign extS   = $signed({ctl.fillSign & laneIn[LANE_W-1], laneIn});
  assign amtM1  = ctl.amt - AMT_W'(1);
  assign plainS = extS >>> ctl.amt;
  assign preS   = extS >>> amtM1;
  assign sumS   = preS + EXT_W'(1);

  always_comb begin
    if (ctl.roundEn) rightRes = LANE_W'(sumS >>> 1);
    else             rightRes = LANE_W'(plainS);
  end

  always_comb begin
    if (ctl.bypass)       laneOut = laneIn;
    else if (ctl.goLeft)  laneOut = leftRes;
    else if (ctl.goRight) laneOut = rightRes;
    else                  laneOut = laneIn;
  end

  assign laneSat = !ctl.bypass && ctl.goLeft && ctl.clampEn && (satHi || satLo);

  // R4: a clamped lane carries one of the two limit codes.
  always_comb begin
    if (laneSat) begin
      a_r4_clamp_code: assert (laneOut == 16'h7FFF || laneOut == 16'h8000);
    end
  end

endmodule

// File: rtl/shift16_dp.sv
module shift16_dp
  import shift16_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  shCtrl_t         ctl,
  input  logic [XLEN-1:0] srcA,
  output logic [XLEN-1:0] dpOut,
  output logic            ovAny
);

  localparam int LANES = XLEN / LANE_W;

  logic [LANES-1:0] satVec;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    shift16_lane u_lane (
      .ctl     (ctl),
      .laneIn  (srcA[k*LANE_W +: LANE_W]),
      .laneOut (dpOut[k*LANE_W +: LANE_W]),
      .laneSat (satVec[k])
    );
  end

  assign ovAny = |satVec;

endmodule

// File: rtl/shift16_unit.sv
module shift16_unit
  import shift16_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inValid,
  input  logic [2:0]      opSel,
  input  logic            useImm,
  input  logic [3:0]      immAmt,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic            outValid,
  output logic [XLEN-1:0] result,
  output logic            ovSet
);

  initial begin
    a_r1_xlen_legal: assert (XLEN == 32 || XLEN == 64);
  end

  shCtrl_t         ctl;
  logic [XLEN-1:0] dpOut;
  logic            ovAny;
  logic            unusedHiB;

  assign unusedHiB = ^srcB[XLEN-1:AMT_W];

  shift16_ctrl u_ctrl (
    .opSel  (opSel),
    .useImm (useImm),
    .immAmt (immAmt),
    .regAmt (srcB[AMT_W-1:0]),
    .ctl    (ctl)
  );

  shift16_dp #(.XLEN(XLEN)) u_dp (
    .ctl   (ctl),
    .srcA  (srcA),
    .dpOut (dpOut),
    .ovAny (ovAny)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      result   <= '0;
      ovSet    <= 1'b0;
    end else begin
      outValid <= inValid;
      ovSet    <= inValid & ovAny;
      if (inValid) result <= dpOut;
    end
  end

  a_r1_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  a_r5_ov_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ovSet |-> outValid);

  a_r5_ov_only_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !(ctl.goLeft && ctl.clampEn)) |=> !ovSet);

  a_r9_zero_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && ctl.amt == '0) |=> (result == $past(srcA) && !ovSet));

  a_r10_reserved_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opSel[2:1] == 2'b11) |=> (result == $past(srcA) && !ovSet));

endmodule

// File: tb/shift16_unit_tb.sv
module shift16_unit_tb;

  localparam int XLEN  = 64;
  localparam int LANES = XLEN / 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            inValid = 1'b0;
  logic [2:0]      opSel = '0;
  logic            useImm = 1'b0;
  logic [3:0]      immAmt = '0;
  logic [XLEN-1:0] srcA = '0;
  logic [XLEN-1:0] srcB = '0;
  logic            outValid;
  logic [XLEN-1:0] result;
  logic            ovSet;

  int nTests = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  shift16_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opSel(opSel),
    .useImm(useImm), .immAmt(immAmt), .srcA(srcA), .srcB(srcB),
    .outValid(outValid), .result(result), .ovSet(ovSet)
  );

  task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference on integers.
  function automatic logic [15:0] refLane(int op, int a, logic [15:0] x, output bit ov);
    int u, s, w;
    ov = 0;
    u = int'(x);
    s = int'($signed(x));
    if (a == 0 || op >= 6) return x;
    case (op)
      0: w = u << a;
      1: begin
        w = s * (1 << a);
        if (w > 32767)       begin w = 32'h7FFF; ov = 1; end
        else if (w < -32768) begin w = 32'h8000; ov = 1; end
      end
      2: w = u >> a;
      3: w = (u + (1 << (a - 1))) >> a;
      4: w = s >>> a;
      default: w = (s + (1 << (a - 1))) >>> a;
    endcase
    return 16'(w);
  endfunction

  function automatic string opTag(int op, int a);
    if (a == 0) return "R9";
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      4: return "R7";
      3, 5: return "R8";
      default: return "R10";
    endcase
  endfunction

  // Called at a negative edge: drive, wait one clock, compare.
  task automatic doOp(int op, bit imm, logic [3:0] ia, logic [XLEN-1:0] a,
                      logic [XLEN-1:0] b, string extra);
    logic [XLEN-1:0] expR;
    bit              expOv, lov;
    int              amt;
    string           t;
    amt = imm ? int'(ia) : int'(b[3:0]);
    expOv = 0;
    for (int k = 0; k < LANES; k++) begin
      expR[k*16 +: 16] = refLane(op, amt, a[k*16 +: 16], lov);
      expOv |= lov;
    end
    inValid = 1'b1; opSel = 3'(op); useImm = imm; immAmt = ia; srcA = a; srcB = b;
    @(negedge clk);
    t = (extra != "") ? extra : opTag(op, amt);
    check({t, " R1 valid"}, XLEN'(outValid), XLEN'(1));
    check({t, " result"}, result, expR);
    check({t, " R5 ovSet"}, XLEN'(ovSet), XLEN'(expOv));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 outValid in reset", XLEN'(outValid), '0);
    check("R11 result in reset", result, '0);
    check("R11 ovSet in reset", XLEN'(ovSet), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: no-wrap rounding corner, logical 0xFFFF >> 1 -> 0x8000.
    doOp(3, 1, 4'd1, {4{16'hFFFF}}, '0, "R8 ffff round");
    check("R8 lane0 0x8000", XLEN'(result[15:0]), XLEN'(16'h8000));
    // R4/R5: mixed lanes, high clamp, low clamp, in range.
    doOp(1, 1, 4'd2, {16'h4000, 16'hC000, 16'h1000, 16'hA000}, '0, "R4 mixed");
    doOp(1, 1, 4'd4, {16'h0001, 16'hFFFF, 16'h07FF, 16'hF800}, '0, "R4 edge");
    doOp(1, 1, 4'd15, {16'h0000, 16'hFFFF, 16'h0000, 16'h0000}, '0, "R4 minus1 by15");
    // R9: zero amount on each code.
    for (int op = 0; op < 8; op++)
      doOp(op, 1, 4'd0, 64'h8001_7FFF_FFFF_1234, '0, "R9 zero amount");
    // R2: register amount, junk in upper bits.
    doOp(4, 0, 4'd9, 64'h8000_7FFF_F00F_0F0F, 64'hFFFF_FFFF_FFFF_FFF3, "R2 reg amount");
    doOp(1, 0, 4'd0, 64'h4000_0001_0002_BFFF, 64'hABCD_0000_0000_0011, "R2 reg high bits");
    // R10: reserved codes.
    doOp(6, 1, 4'd5, 64'h1234_5678_9ABC_DEF0, '0, "R10 code6");
    doOp(7, 0, 4'd0, 64'hFEDC_BA98_7654_3210, 64'h7, "R10 code7");
    // R8 arithmetic rounding toward +inf at halves.
    doOp(5, 1, 4'd1, {16'hFFFF, 16'h7FFF, 16'h8000, 16'hFFFD}, '0, "R8 sra round");
    doOp(5, 1, 4'd15, {16'h8000, 16'h4000, 16'h3FFF, 16'hC000}, '0, "R8 sra round15");
    // R1: valid drops after idle cycle.
    inValid = 1'b0;
    @(negedge clk);
    check("R1 outValid idle", XLEN'(outValid), '0);
    check("R5 ovSet idle", XLEN'(ovSet), '0);

    // Random sweep over codes, sources and amounts.
    for (int i = 0; i < 1500; i++) begin
      logic [XLEN-1:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      doOp(int'($urandom_range(7, 0)), 1'($urandom), 4'($urandom), ra, rb, "");
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule